// File: doc/BRIEF.md
# Pitch-Synchronous Formant Resonator

This block is one second-order recursive section that shapes the spectrum around a single formant. Each accepted sample strobe produces one output sample from the new input and the two previous outputs: y[n] = A·x[n] + B·y[n−1] + C·y[n−2]. The coefficients are signed fixed point with 14 fractional bits, so 1.0 is 16384. Samples are 16-bit two's complement. The coefficients are computed elsewhere. The usual choice sets A = 1 − B − C for unity gain at DC, C = −exp(−2π·BW·T) and B = 2·exp(−π·BW·T)·cos(2π·F·T).

The block holds two coefficient sets: one for the closed phase of the glottal cycle and one for the open phase. The open-phase set carries the raised frequency and wider bandwidth that the first formant shows while the glottis is open. Software or a frame sequencer rewrites the sets once per 5 ms parameter frame. The open-phase flag, sampled together with each strobe, chooses which set that sample uses. The block therefore follows the pitch period sample by sample with no rewrite inside the frame.

One multiplier is shared across three cycles. The controller steps through four named states:
- IDLE waits for a strobe. A strobe seen in IDLE is accepted: IDLE→TAP_X.
- TAP_X accumulates A·x.
- TAP_Y1 adds B·y[n−1].
- TAP_Y2 adds C·y[n−2], rounds, saturates and shifts the history, then returns to IDLE.

The transitions TAP_X→TAP_Y1→TAP_Y2→IDLE are unconditional.

Top module: `formant_section`

## Requirements
- R1: After reset, smp_out is 0 and busy and done are both low.
- R2: The result of an accepted sample is the saturation of floor((A·x + B·y1 + C·y2 + 8192) / 16384). Here y1 and y2 are the previous two results, and A, B, C are signed with 14 fractional bits. After the sample, y2 takes the old y1 and y1 takes the new result.
- R3: busy is high for exactly the three cycles after the accepting edge. The result appears on smp_out, and done is high for exactly one cycle, starting at the third clock edge after the accepting edge.
- R4: A strobe that arrives while busy is high is ignored. It produces no extra done pulse and no change to smp_out.
- R5: open_phase high at the accepting edge selects the open-phase set (bank 1). Low selects the closed-phase set (bank 0).
- R6: A coefficient write (coef_wr, with coef_bank_sel 0 = closed set, 1 = open set) takes effect from the next accepted strobe. A write made during a computation, or on the accepting edge itself, does not alter that computation.
- R7: A result above 32767 is clamped to 32767. A result below −32768 is clamped to −32768.
- R8: clr high at a clock edge zeroes both stored previous outputs, so smp_out reads 0 afterwards. clr wins over a result written at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Zero the filter history |
| coef_wr | input | 1 | Write one coefficient set |
| coef_bank_sel | input | 1 | Set written: 0 closed phase, 1 open phase |
| coef_a | input | COEF_W | Input gain A |
| coef_b | input | COEF_W | First feedback B |
| coef_c | input | COEF_W | Second feedback C |
| smp_stb | input | 1 | Start one sample |
| smp_in | input | SAMPLE_W | Input sample x[n] |
| open_phase | input | 1 | Glottis-open flag for this sample |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle result strobe |
| smp_out | output | SAMPLE_W | Latest result y[n−1] |

## Verification
The bench builds the block with its defaults: 16-bit samples, 16-bit coefficients and 14 fractional bits. With these values A can approach 2.0 and feedback can approach ±2.0, so a full-scale input drives the rounded sum past both rails, and the clamp is reached in directed cases. The narrow format also makes the half-LSB rounding visible after every sample. Random coefficient sets therefore exercise sign handling in the 34-bit accumulator on every tap, and a small ringing filter checks that the two history registers shift in the right order.

// File: rtl/fres_pkg.sv
package fres_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TAP_X  = 2'd1,
        ST_TAP_Y1 = 2'd2,
        ST_TAP_Y2 = 2'd3
    } fres_state_e;
endpackage

// File: rtl/fres_ctrl.sv
module fres_ctrl
    import fres_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        smp_stb,
    output fres_state_e state,
    output logic        accept,
    output logic        busy,
    output logic        done
);
    fres_state_e state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   state_nxt = smp_stb ? ST_TAP_X : ST_IDLE;
            ST_TAP_X:  state_nxt = ST_TAP_Y1;
            ST_TAP_Y1: state_nxt = ST_TAP_Y2;
            ST_TAP_Y2: state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        accept = smp_stb && (state == ST_IDLE);
        busy   = (state != ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= (state == ST_TAP_Y2);
    end

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3
    busy_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy ##1 busy ##1 (!busy && done));
    // R4
    stb_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && smp_stb && state == ST_TAP_Y2) |=> (state == ST_IDLE));
endmodule

// File: rtl/fres_coef_bank.sv
module fres_coef_bank
    import fres_pkg::*;
#(
    parameter int COEF_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     wr_bank,
    input  logic signed [COEF_W-1:0] wr_a,
    input  logic signed [COEF_W-1:0] wr_b,
    input  logic signed [COEF_W-1:0] wr_c,
    input  logic                     load,
    input  logic                     load_bank,
    input  fres_state_e              state,
    output logic signed [COEF_W-1:0] act_a,
    output logic signed [COEF_W-1:0] act_b,
    output logic signed [COEF_W-1:0] act_c
);
    localparam int NBANK = 2;

    for (genvar g = 0; g < NBANK; g++) begin : bank_g
        logic signed [COEF_W-1:0] ra, rb, rc;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ra <= '0;
                rb <= '0;
                rc <= '0;
            end else if (wr_en && (wr_bank == 1'(g))) begin
                ra <= wr_a;
                rb <= wr_b;
                rc <= wr_c;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_a <= '0;
            act_b <= '0;
            act_c <= '0;
        end else if (load) begin
            act_a <= load_bank ? bank_g[1].ra : bank_g[0].ra;
            act_b <= load_bank ? bank_g[1].rb : bank_g[0].rb;
            act_c <= load_bank ? bank_g[1].rc : bank_g[0].rc;
        end
    end

    // R6
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE)
            |-> ($stable(act_a) && $stable(act_b) && $stable(act_c)));
endmodule

// File: rtl/fres_datapath.sv
module fres_datapath
    import fres_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int COEF_W   = 16,
    parameter int FRAC     = 14
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       load,
    input  logic signed [SAMPLE_W-1:0] x_in,
    input  fres_state_e                state,
    input  logic signed [COEF_W-1:0]   ca,
    input  logic signed [COEF_W-1:0]   cb,
    input  logic signed [COEF_W-1:0]   cc,
    output logic signed [SAMPLE_W-1:0] y_out
);
    localparam int PROD_W = SAMPLE_W + COEF_W;
    localparam int ACC_W  = PROD_W + 2;
    localparam logic signed [ACC_W-1:0] RND    = ACC_W'(1) <<< (FRAC - 1);
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 <<< (SAMPLE_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - ACC_W'(1);

    logic signed [SAMPLE_W-1:0] x_q, y1_q, y2_q, y_nxt;
    logic signed [COEF_W-1:0]   op_c;
    logic signed [SAMPLE_W-1:0] op_s;
    logic signed [PROD_W-1:0]   prod;
    logic signed [ACC_W-1:0]    prod_ext, acc, sum_all, shifted;

    always_comb begin
        unique case (state)
            ST_TAP_X:  begin op_c = ca; op_s = x_q;  end
            ST_TAP_Y1: begin op_c = cb; op_s = y1_q; end
            ST_TAP_Y2: begin op_c = cc; op_s = y2_q; end
            default:   begin op_c = '0; op_s = '0;   end
        endcase
        prod     = op_c * op_s;
        prod_ext = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
        sum_all  = acc + prod_ext;
        shifted  = (sum_all + RND) >>> FRAC;
        if (shifted > SAT_HI)      y_nxt = SAT_HI[SAMPLE_W-1:0];
        else if (shifted < SAT_LO) y_nxt = SAT_LO[SAMPLE_W-1:0];
        else                       y_nxt = shifted[SAMPLE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
            acc <= '0;
        end else begin
            if (load) x_q <= x_in;
            if (state == ST_TAP_X)       acc <= prod_ext;
            else if (state == ST_TAP_Y1) acc <= sum_all;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            y1_q <= '0;
            y2_q <= '0;
        end else if (state == ST_TAP_Y2) begin
            y2_q <= y1_q;
            y1_q <= y_nxt;
        end
    end

    assign y_out = y1_q;

    // R8
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (y1_q == '0 && y2_q == '0));
    // R2
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_TAP_Y2 && !$past(clr)) |-> (y2_q == $past(y1_q)));
    // R3
    out_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(y1_q) |-> ($past(state) == ST_TAP_Y2 || $past(clr)));
endmodule

// File: rtl/formant_section.sv
module formant_section
    import fres_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int COEF_W   = 16,
    parameter int FRAC     = 14
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       coef_wr,
    input  logic                       coef_bank_sel,
    input  logic signed [COEF_W-1:0]   coef_a,
    input  logic signed [COEF_W-1:0]   coef_b,
    input  logic signed [COEF_W-1:0]   coef_c,
    input  logic                       smp_stb,
    input  logic signed [SAMPLE_W-1:0] smp_in,
    input  logic                       open_phase,
    output logic                       busy,
    output logic                       done,
    output logic signed [SAMPLE_W-1:0] smp_out
);
    fres_state_e              state;
    logic                     accept;
    logic signed [COEF_W-1:0] act_a, act_b, act_c;

    fres_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_stb(smp_stb),
        .state  (state),
        .accept (accept),
        .busy   (busy),
        .done   (done)
    );

    fres_coef_bank #(.COEF_W(COEF_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (coef_wr),
        .wr_bank  (coef_bank_sel),
        .wr_a     (coef_a),
        .wr_b     (coef_b),
        .wr_c     (coef_c),
        .load     (accept),
        .load_bank(open_phase),
        .state    (state),
        .act_a    (act_a),
        .act_b    (act_b),
        .act_c    (act_c)
    );

    fres_datapath #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .FRAC(FRAC)) u_dp (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .load (accept),
        .x_in (smp_in),
        .state(state),
        .ca   (act_a),
        .cb   (act_b),
        .cc   (act_c),
        .y_out(smp_out)
    );
endmodule

// File: tb/formant_section_test.sv
module formant_section_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0, coef_wr = 1'b0, coef_bank_sel = 1'b0;
    logic signed [15:0] coef_a = '0, coef_b = '0, coef_c = '0;
    logic smp_stb = 1'b0, open_phase = 1'b0;
    logic signed [15:0] smp_in = '0;
    logic busy, done;
    logic signed [15:0] smp_out;

    int checks = 0, failures = 0;
    int sh_a[2], sh_b[2], sh_c[2];
    int my1 = 0, my2 = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    formant_section uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .coef_wr(coef_wr),
        .coef_bank_sel(coef_bank_sel), .coef_a(coef_a), .coef_b(coef_b),
        .coef_c(coef_c), .smp_stb(smp_stb), .smp_in(smp_in),
        .open_phase(open_phase), .busy(busy), .done(done), .smp_out(smp_out)
    );

    function automatic int ref_y(int a, int b, int c, int x, int y1, int y2);
        longint s;
        s = longint'(a) * x + longint'(b) * y1 + longint'(c) * y2 + 8192;
        s = s >>> 14;
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return int'(s);
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic write_bank(bit bk, int a, int b, int c);
        @(negedge clk);
        coef_wr = 1; coef_bank_sel = bk;
        coef_a = 16'(a); coef_b = 16'(b); coef_c = 16'(c);
        sh_a[bk] = a; sh_b[bk] = b; sh_c[bk] = c;
        @(negedge clk);
        coef_wr = 0;
    endtask

    task automatic do_clear();
        @(negedge clk); clr = 1;
        @(negedge clk); clr = 0;
        my1 = 0; my2 = 0;
        chk(smp_out == 0, "R8 clr", smp_out, 0);
    endtask

    // extra: second strobe during busy; mid_wr: write bank 0 during busy
    task automatic run_sample(int x, bit op, bit extra, bit mid_wr, int na, int nb, int nc);
        int a, b, c, e;
        @(negedge clk);
        smp_stb = 1; smp_in = 16'(x); open_phase = op;
        a = sh_a[op]; b = sh_b[op]; c = sh_c[op];
        e = ref_y(a, b, c, x, my1, my2);
        @(negedge clk);
        smp_stb = 0;
        chk(busy == 1, "R3 busy after accept", busy, 1);
        if (extra) begin smp_stb = 1; smp_in = 16'(~x); open_phase = ~op; end
        if (mid_wr) begin
            coef_wr = 1; coef_bank_sel = 0;
            coef_a = 16'(na); coef_b = 16'(nb); coef_c = 16'(nc);
            sh_a[0] = na; sh_b[0] = nb; sh_c[0] = nc;
        end
        @(negedge clk);
        smp_stb = 0; coef_wr = 0;
        @(negedge clk);
        chk(done == 0, "R3 done early", done, 0);
        @(negedge clk);
        chk(done == 1, "R3 done pulse", done, 1);
        chk(busy == 0, "R3 busy ends", busy, 0);
        chk(smp_out == 16'(e), mid_wr ? "R6 write mid-sample" :
            (op ? "R5 open bank result" : "R2 result"), smp_out, e);
        my2 = my1; my1 = e;
        @(negedge clk);
        chk(done == 0, "R3 done single cycle", done, 0);
        if (extra) begin
            @(negedge clk);
            chk(done == 0 && smp_out == 16'(e), "R4 busy strobe ignored", smp_out, e);
            chk(busy == 0, "R4 no restart", busy, 0);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd1357);
        sh_a = '{0, 0}; sh_b = '{0, 0}; sh_c = '{0, 0};
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk(smp_out == 0, "R1 reset output", smp_out, 0);
        chk(busy == 0 && done == 0, "R1 reset flags", {busy, done}, 0);

        // R2: ringing closed-phase filter, impulse then zeros
        write_bank(0, 4915, 19661, -8192);
        write_bank(1, 7384, 15000, -6000);
        run_sample(10000, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 6; i++) run_sample(0, 0, 0, 0, 0, 0, 0);
        // R5: alternate phase per sample
        for (int i = 0; i < 8; i++) run_sample(3000 - i * 900, 1'(i % 2), 0, 0, 0, 0, 0);

        // R4: strobe while busy
        run_sample(1234, 0, 1, 0, 0, 0, 0);

        // R6: write during computation, then the next sample sees it
        run_sample(-2000, 0, 0, 1, 8000, 4000, -2000);
        run_sample(500, 0, 0, 0, 0, 0, 0);

        // R8: clear, then zero input must give zero output
        do_clear();
        run_sample(0, 0, 0, 0, 0, 0, 0);

        // R7: saturation at both rails
        write_bank(0, 32767, 0, 0);
        run_sample(32767, 0, 0, 0, 0, 0, 0);
        chk(smp_out == 32767, "R7 clamp high", smp_out, 32767);
        run_sample(-32768, 0, 0, 0, 0, 0, 0);
        chk(smp_out == -32768, "R7 clamp low", smp_out, -32768);

        // random mix
        for (int i = 0; i < 300; i++) begin
            int r;
            r = int'($urandom % 16);
            if (r == 0) write_bank(1'($urandom % 2), int'($signed(16'($urandom))),
                                   int'($signed(16'($urandom))), int'($signed(16'($urandom))));
            else if (r == 1) do_clear();
            run_sample(int'($signed(16'($urandom))), 1'($urandom % 2),
                       (r == 2), 0, 0, 0, 0);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule